// File: doc/BRIEF.md
# Predictive Dead-Time Adjuster

This block takes a single PWM request and turns it into two gate enables, one for the high-side switch and one for the low-side synchronous rectifier, with a dead interval between them. There are two dead intervals. One runs from low-side off to high-side on. The other runs from high-side off to low-side on.

Each interval has its own trim counter, and the interval lasts trim+1 clock ticks. During a dead interval, a digital flag reports whether the switch node fell below the negative sense threshold, which means the body diode was conducting. The counter uses that result only for the next interval of the same kind:
- If conduction was seen, the trim steps down so that the next dead time is shorter.
- If no conduction was seen, the trim steps up and backs away from shoot-through.

Over many switching cycles the dead times settle at the shortest value that keeps the diode quiet.

All pins are plain level-sensitive control pins sampled on the clock. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure. The enable pin is a synchronous soft-off. Reset is asynchronous and active low.

Top module: `predictive_deadtime`

## Requirements
- R1: While reset is asserted or `en` is low, `hs_on` and `ls_on` are low and both trims are loaded with their maximum (15 for the default 4-bit width). The first dead interval after enabling therefore lasts 16 cycles.
- R2: `hs_on` and `ls_on` are never high in the same cycle.
- R3: Suppose `pwm_req` is sampled high while the low side conducts, or while enabled and idle. Then both outputs are low for exactly trim_lh+1 cycles, after which `hs_on` rises.
- R4: Suppose `pwm_req` is sampled low while the high side conducts, or while enabled and idle. Then both outputs are low for exactly trim_hl+1 cycles, after which `ls_on` rises.
- R5: If `diode_flag` is high in any cycle of a dead interval, that interval's trim decreases by one when the interval ends. It stops at 0, which gives a one-cycle dead time.
- R6: If `diode_flag` stays low for a whole dead interval, that interval's trim increases by one when it ends. It stops at 15, which gives a 16-cycle dead time.
- R7: A trim change takes effect only in the next interval of the same kind. An interval's own length is fixed by the trim held when it began.
- R8: The two trims are independent. Diode conduction seen in one kind of interval does not change the other trim.
- R9: A dead interval, once started, always runs to its end. `pwm_req` changes during it are acted on only afterwards, so a conducting phase lasts at least one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick is one delay step |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces both gates off and trims to maximum |
| pwm_req | input | 1 | PWM command: high requests the high side, low the low side |
| diode_flag | input | 1 | Switch node below the negative sense threshold (body-diode conduction) |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |

## Verification
The bench builds the block with the default 4-bit trim width, so each dead time spans 1 to 16 ticks. With 40-cycle PWM phases, both saturation ends can be reached within about twenty switching periods. A scripted diode-flag pattern drives both trims down to the one-cycle floor and back up to the 16-cycle ceiling. It also shrinks one interval while the other grows. The short range also makes it cheap to place a PWM pulse inside a long dead interval and to disable the block while the high side is on.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEAD_LH,
    PH_HIGH,
    PH_DEAD_HL,
    PH_LOW
  } phase_t;

  localparam int N_GAPS = 2;
  localparam int GAP_LH = 0;
  localparam int GAP_HL = 1;
endpackage

// File: rtl/pdt_trim.sv
module pdt_trim #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             active,
  input  logic             done,
  input  logic             diode,
  output logic [CNT_W-1:0] trim
);
  localparam logic [CNT_W-1:0] TRIM_MAX = '1;
  localparam logic [CNT_W-1:0] TRIM_MIN = '0;

  logic seen;
  logic hit;

  assign hit = seen | diode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim <= TRIM_MAX;
      seen <= 1'b0;
    end else if (!en) begin
      trim <= TRIM_MAX;
      seen <= 1'b0;
    end else if (done) begin
      seen <= 1'b0;
      if (hit) begin
        if (trim != TRIM_MIN) trim <= trim - 1'b1;
      end else if (trim != TRIM_MAX) begin
        trim <= trim + 1'b1;
      end
    end else if (active && diode) begin
      seen <= 1'b1;
    end
  end

  // R5 / R6: trim moves by at most one step per cycle
  a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |->
      ((trim == $past(trim)) || (trim == $past(trim) + 1'b1) || (trim + 1'b1 == $past(trim))));

  // R1: disabled block holds the maximum trim
  a_r1_trim_max: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (trim == TRIM_MAX));

  // R7: trim changes only at the end of its own interval
  a_r7_change_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !done) |=> (trim == $past(trim)) || !en);

  // R3: end-of-interval strobe comes only from inside the interval
  a_r3_done_inside: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> active);
endmodule

// File: rtl/pdt_sequencer.sv
module pdt_sequencer
  import pdt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pwm_req,
  input  logic [CNT_W-1:0] trim_lh,
  input  logic [CNT_W-1:0] trim_hl,
  output logic             active_lh,
  output logic             active_hl,
  output logic             done_lh,
  output logic             done_hl,
  output logic             hs_on,
  output logic             ls_on
);
  phase_t           phase, phase_nxt;
  logic [CNT_W-1:0] timer;

  assign active_lh = (phase == PH_DEAD_LH);
  assign active_hl = (phase == PH_DEAD_HL);
  assign done_lh   = active_lh && (timer == trim_lh);
  assign done_hl   = active_hl && (timer == trim_hl);
  assign hs_on     = (phase == PH_HIGH);
  assign ls_on     = (phase == PH_LOW);

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_IDLE:    phase_nxt = pwm_req ? PH_DEAD_LH : PH_DEAD_HL;
      PH_DEAD_LH: if (done_lh) phase_nxt = PH_HIGH;
      PH_HIGH:    if (!pwm_req) phase_nxt = PH_DEAD_HL;
      PH_DEAD_HL: if (done_hl) phase_nxt = PH_LOW;
      PH_LOW:     if (pwm_req) phase_nxt = PH_DEAD_LH;
      default:    phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      timer <= '0;
    end else if (!en) begin
      phase <= PH_IDLE;
      timer <= '0;
    end else begin
      phase <= phase_nxt;
      timer <= (phase_nxt != phase) ? '0 : timer + 1'b1;
    end
  end

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));

  // R3: high side rises only after a cycle with the low side off
  a_r3_hs_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> !$past(ls_on));

  // R4: low side rises only after a cycle with the high side off
  a_r4_ls_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> !$past(hs_on));

  a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hs_on && !ls_on));
endmodule

// File: rtl/predictive_deadtime.sv
module predictive_deadtime
  import pdt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pwm_req,
  input  logic diode_flag,
  output logic hs_on,
  output logic ls_on
);
  logic [CNT_W-1:0] trim   [N_GAPS];
  logic             active [N_GAPS];
  logic             done   [N_GAPS];

  pdt_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .pwm_req   (pwm_req),
    .trim_lh   (trim[GAP_LH]),
    .trim_hl   (trim[GAP_HL]),
    .active_lh (active[GAP_LH]),
    .active_hl (active[GAP_HL]),
    .done_lh   (done[GAP_LH]),
    .done_hl   (done[GAP_HL]),
    .hs_on     (hs_on),
    .ls_on     (ls_on)
  );

  for (genvar g = 0; g < N_GAPS; g++) begin : g_trim
    pdt_trim #(.CNT_W(CNT_W)) u_trim (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .active (active[g]),
      .done   (done[g]),
      .diode  (diode_flag),
      .trim   (trim[g])
    );
  end
endmodule

// File: tb/tb_predictive_deadtime.sv
`timescale 1ns/1ps
module tb_predictive_deadtime;
  logic clk = 1'b0;
  logic rst_n, en, pwm_req, diode_flag;
  logic hs_on, ls_on;

  always #5 clk = ~clk;

  predictive_deadtime dut (
    .clk(clk), .rst_n(rst_n), .en(en), .pwm_req(pwm_req),
    .diode_flag(diode_flag), .hs_on(hs_on), .ls_on(ls_on)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model: 0 idle, 1 dead before high, 2 high, 3 dead before low, 4 low
  int m_mode = 0;
  int m_rem = 0;
  int m_trim[2] = '{15, 15};
  bit m_seen[2] = '{0, 0};

  bit flag_lh = 0, flag_hl = 0;
  int last_on = 0;  // 1 low side, 2 high side
  int run = 0;
  int last_lh = 0, last_hl = 0;
  int lh_q[$];
  int hl_q[$];

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int bump(int t, bit hit);
    if (hit) return (t > 0) ? t - 1 : 0;
    return (t < 15) ? t + 1 : 15;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !en) begin
      m_mode = 0; m_trim = '{15, 15}; m_seen = '{0, 0};
    end else begin
      case (m_mode)
        0: if (pwm_req) begin m_mode = 1; m_rem = m_trim[0] + 1; end
           else begin m_mode = 3; m_rem = m_trim[1] + 1; end
        1: begin
             m_seen[0] = m_seen[0] | diode_flag;
             m_rem--;
             if (m_rem == 0) begin
               m_trim[0] = bump(m_trim[0], m_seen[0]); m_seen[0] = 0; m_mode = 2;
             end
           end
        2: if (!pwm_req) begin m_mode = 3; m_rem = m_trim[1] + 1; end
        3: begin
             m_seen[1] = m_seen[1] | diode_flag;
             m_rem--;
             if (m_rem == 0) begin
               m_trim[1] = bump(m_trim[1], m_seen[1]); m_seen[1] = 0; m_mode = 4;
             end
           end
        default: if (pwm_req) begin m_mode = 1; m_rem = m_trim[0] + 1; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2/R3 hs_on vs model", hs_on, m_mode == 2);
      check("R2/R4 ls_on vs model", ls_on, m_mode == 4);
      check("R2 overlap", hs_on && ls_on, 0);
    end
    if (!en) run = 0;
    else if (!hs_on && !ls_on) run++;
    else begin
      if (run > 0) begin
        if (hs_on) begin last_lh = run; lh_q.push_back(run); end
        else begin last_hl = run; hl_q.push_back(run); end
      end
      run = 0;
    end
    if (hs_on) last_on = 2;
    if (ls_on) last_on = 1;
    diode_flag = (!hs_on && !ls_on) &&
                 ((last_on == 1 && flag_lh) || (last_on == 2 && flag_hl));
  end

  task automatic periods(int n, int hi, int lo);
    for (int i = 0; i < n; i++) begin
      pwm_req = 1; repeat (hi) @(negedge clk);
      pwm_req = 0; repeat (lo) @(negedge clk);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    rst_n = 0; en = 0; pwm_req = 0; diode_flag = 0;
    repeat (3) @(negedge clk);
    check("R1 hs low in reset", hs_on, 0);
    check("R1 ls low in reset", ls_on, 0);
    rst_n = 1;
    @(negedge clk);
    pwm_req = 1; en = 1;
    begin
      int k = 0;
      @(negedge clk);
      while (!hs_on && k < 40) begin k++; @(negedge clk); end
      check("R1 first dead time uses max trim", k, 16);
    end
    // both intervals see conduction: trims fall to the floor
    flag_lh = 1; flag_hl = 1;
    periods(20, 40, 40);
    check("R5 lh gap at floor", last_lh, 1);
    check("R5 hl gap at floor", last_hl, 1);
    // conduction stops: gaps grow one step per cycle, starting next cycle
    flag_lh = 0; flag_hl = 0;
    lh_q.delete(); hl_q.delete();
    periods(3, 40, 40);
    check("R7 R3 lh count", lh_q.size(), 3);
    check("R7 R4 hl count", hl_q.size(), 3);
    for (int i = 0; i < 3; i++) begin
      if (i < lh_q.size()) check("R7 R3 lh gap sequence", lh_q[i], i + 1);
      if (i < hl_q.size()) check("R6 R4 hl gap sequence", hl_q[i], i + 1);
    end
    periods(20, 40, 40);
    check("R6 lh gap at ceiling", last_lh, 16);
    check("R6 hl gap at ceiling", last_hl, 16);
    // only one kind of interval conducts
    flag_lh = 1;
    periods(20, 40, 40);
    check("R8 lh gap shrinks", last_lh, 1);
    check("R8 hl gap unaffected", last_hl, 16);
    // short pulse lands inside a dead interval
    begin
      int hs_cnt = 0;
      pwm_req = 1; @(negedge clk);
      pwm_req = 0;
      for (int i = 0; i < 30; i++) begin
        if (hs_on) hs_cnt++;
        @(negedge clk);
      end
      check("R9 high phase one cycle", hs_cnt, 1);
      check("R9 low side back on", ls_on, 1);
    end
    // disable while the high side conducts
    pwm_req = 1;
    repeat (10) @(negedge clk);
    check("R3 hs on before disable", hs_on, 1);
    en = 0;
    @(negedge clk);
    check("R1 hs off after disable", hs_on, 0);
    check("R1 ls off after disable", ls_on, 0);
    flag_lh = 0;
    pwm_req = 0; en = 1;
    begin
      int k = 0;
      @(negedge clk);
      while (!ls_on && k < 40) begin k++; @(negedge clk); end
      check("R1 R4 hl trim back at max", k, 16);
    end
    repeat (5) @(negedge clk);
    summary();
  end
endmodule